// File: doc/BRIEF.md
# Indirect-Indexed Codec Register Port

This block is the control-register port of an audio codec, seen from a host bus as four byte-wide locations selected by a 2-bit address. Location 0 holds a pointer register, location 1 is a data window onto a bank of 32 byte-wide configuration registers, location 2 returns a status byte and location 3 is a programmed-I/O location that this port does not serve. The host writes the pointer first and then reads or writes the window to reach the selected configuration register.

The pointer register carries three flag bits in its upper part: an initialisation flag in bit 7, a mode-change-enable flag in bit 6 and a transfer-request-disable flag in bit 5. The low bits choose the configuration register. How many low bits are used depends on the variant chosen at build time and, in the extended variant, on a wide-index mode bit held in configuration register 12. The initialisation flag and the status byte are driven only from dedicated test inputs, because no bus operation sets them. In the extended variant, configuration slot 25 always reads back a fixed identification byte.

A read is registered. An access state machine has three named states: `ACC_IDLE` (no response), `ACC_DATA` (read data valid) and `ACC_FAULT` (programmed-I/O read rejected). From any state, a read strobe to offsets 0–2 moves to `ACC_DATA`, a read strobe to offset 3 moves to `ACC_FAULT`, and a cycle with no read strobe returns to `ACC_IDLE`.

Top module: `codec_regport`

## Requirements
- R1: After reset the pointer register is 0x00, the status byte is 0x00, all 32 configuration registers are 0x00, and `rsp_valid` and `rsp_fault` are low.
- R2: A bus write to offset 0 replaces pointer bits 6..0 and leaves bit 7 unchanged; bit 7 changes only through `tst_init_we`/`tst_init_val`; a read of offset 0 returns all eight bits.
- R3: The effective index is pointer bits 3..0 (bit 4 forced to 0); in the extended variant (`EXTENDED`=1) it is pointer bits 4..0 while bit 6 of configuration register 12 is 1.
- R4: In the legacy variant (`EXTENDED`=0) bit 6 of register 12 is stored but has no effect on the index, so slots 16–31 are never reached.
- R5: In the extended variant a window read of slot 25 returns 0xA0 whatever was written there; a write to slot 25 is stored without becoming visible.
- R6: A read strobe to offsets 0, 1 or 2 yields `rsp_valid` high with the data on `rsp_data` in the clock cycle after the strobe, for that one cycle only; without a read strobe `rsp_valid` and `rsp_fault` are low in the next cycle.
- R7: A read strobe to offset 3 yields `rsp_fault` high for one cycle, `rsp_valid` low and `rsp_data` 0x00 in the next cycle.
- R8: A read of offset 2 returns the status byte, which is loaded only by `tst_status_we`; bus writes to offsets 2 and 3 change no state.
- R9: When a read and a write (bus write or test load) fall in the same cycle, the read returns the contents from before that write.
- R10: A window write stores the byte into the configuration register at the effective index, and a later window read at that index returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Direct location: 0 pointer, 1 window, 2 status, 3 programmed I/O |
| host_wdata | input | 8 | Write byte |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| tst_status_we | input | 1 | Load the status byte |
| tst_status_val | input | 8 | Status byte to load |
| tst_init_we | input | 1 | Load the pointer initialisation flag |
| tst_init_val | input | 1 | Value for the initialisation flag |
| rsp_data | output | 8 | Read data, valid with `rsp_valid` |
| rsp_valid | output | 1 | Read response valid |
| rsp_fault | output | 1 | Programmed-I/O read rejected |

## Verification
The two functions that can coincide are a register update (a pointer or window write from the bus, or a status or flag load from the test inputs) and a registered read of the same location. The bench raises both strobes in one cycle on the pointer, the window and the status byte, and expects the response of the following cycle to carry the value from before the update, then reads again to see the new value. Both variants are driven with the same stimulus, so the wide-index mode bit is judged by the different slots the two instances reach.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;

    // Direct locations on the host side
    typedef enum logic [1:0] {
        LOC_POINTER = 2'd0,
        LOC_WINDOW  = 2'd1,
        LOC_STATUS  = 2'd2,
        LOC_PIO     = 2'd3
    } loc_e;

    // Read response states
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_FAULT = 2'd2
    } acc_state_e;

    // Pointer register flag positions
    localparam int PTR_INIT_BIT = 7;
    localparam int PTR_MCE_BIT  = 6;
    localparam int PTR_TRD_BIT  = 5;

endpackage

// File: rtl/codec_pointer_reg.sv
module codec_pointer_reg
    import codec_regport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          init_we,
    input  logic          init_val,
    output logic [DW-1:0] ptr_q
);

    localparam int LOW_W = PTR_INIT_BIT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            if (wr_en) begin
                ptr_q[LOW_W-1:0] <= wdata[LOW_W-1:0];
            end
            if (init_we) begin
                ptr_q[PTR_INIT_BIT] <= init_val;
            end
        end
    end

    AST_INIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_we) |=> (ptr_q[PTR_INIT_BIT] == $past(ptr_q[PTR_INIT_BIT]))); // R2

    AST_LOW_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en) |=> (ptr_q[LOW_W-1:0] == $past(wdata[LOW_W-1:0]))); // R2

endmodule

// File: rtl/codec_index_mask.sv
module codec_index_mask #(
    parameter bit EXTENDED = 1'b1,
    parameter int IDX_W    = 5
) (
    input  logic [IDX_W-1:0] ptr_low,
    input  logic             wide_mode,
    output logic [IDX_W-1:0] eff_idx
);

    localparam int NARROW_W = IDX_W - 1;

    logic wide_ok;

    generate
        if (EXTENDED) begin : g_ext
            assign wide_ok = wide_mode;
        end else begin : g_leg
            assign wide_ok = 1'b0 & wide_mode;
        end
    endgenerate

    always_comb begin
        if (wide_ok) begin
            eff_idx = ptr_low;
        end else begin
            eff_idx = {1'b0, ptr_low[NARROW_W-1:0]};
        end
    end

endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank #(
    parameter bit EXTENDED  = 1'b1,
    parameter int DW        = 8,
    parameter int DEPTH     = 32,
    parameter int ID_SLOT   = 25,
    parameter int ID_VALUE  = 8'hA0,
    parameter int MISC_SLOT = 12,
    parameter int WIDE_BIT  = 6,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             wide_mode
);

    localparam logic [IDX_W-1:0] ID_IDX = IDX_W'(ID_SLOT);
    localparam logic [DW-1:0]    ID_BYTE = DW'(ID_VALUE);

    logic [DW-1:0] regs [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[i] <= '0;
                end else if (we && (idx == IDX_W'(i))) begin
                    regs[i] <= wdata;
                end
            end
        end
    endgenerate

    assign wide_mode = regs[MISC_SLOT][WIDE_BIT];

    generate
        if (EXTENDED) begin : g_id
            assign rdata = (idx == ID_IDX) ? ID_BYTE : regs[idx];
        end else begin : g_plain
            assign rdata = regs[idx];
        end
    endgenerate

    AST_SLOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we) |=> (regs[$past(idx)] == $past(wdata))); // R10

endmodule

// File: rtl/codec_access_fsm.sv
module codec_access_fsm
    import codec_regport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] sel_data,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_valid,
    output logic          rsp_fault
);

    acc_state_e state_q, state_d;
    logic [DW-1:0] data_q;

    // Next-state logic
    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_DATA, ACC_FAULT: begin
                if (rd) begin
                    state_d = (sel == LOC_PIO) ? ACC_FAULT : ACC_DATA;
                end else begin
                    state_d = ACC_IDLE;
                end
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // State register and captured read byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd) begin
                data_q <= (sel == LOC_PIO) ? '0 : sel_data;
            end
        end
    end

    // Outputs
    always_comb begin
        rsp_data  = '0;
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            ACC_IDLE: ;
            ACC_DATA: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            ACC_FAULT: rsp_fault = 1'b1;
            default: ;
        endcase
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel != LOC_PIO)) |=> (rsp_valid && !rsp_fault)); // R6

    AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd) |=> (!rsp_valid && !rsp_fault)); // R6

    AST_PIO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel == LOC_PIO)) |=> (rsp_fault && !rsp_valid && (rsp_data == '0))); // R7

endmodule

// File: rtl/codec_regport.sv
module codec_regport
    import codec_regport_pkg::*;
#(
    parameter bit EXTENDED  = 1'b1,
    parameter int DW        = 8,
    parameter int DEPTH     = 32,
    parameter int ID_SLOT   = 25,
    parameter int ID_VALUE  = 8'hA0,
    parameter int MISC_SLOT = 12,
    parameter int WIDE_BIT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_sel,
    input  logic [7:0]    host_wdata,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          tst_status_we,
    input  logic [7:0]    tst_status_val,
    input  logic          tst_init_we,
    input  logic          tst_init_val,
    output logic [7:0]    rsp_data,
    output logic          rsp_valid,
    output logic          rsp_fault
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [DW-1:0]    ptr_q;
    logic [DW-1:0]    status_q;
    logic [DW-1:0]    bank_rdata;
    logic [DW-1:0]    sel_data;
    logic [IDX_W-1:0] eff_idx;
    logic             wide_mode;
    logic             ptr_wr;
    logic             win_wr;

    assign ptr_wr = host_wr && (host_sel == LOC_POINTER);
    assign win_wr = host_wr && (host_sel == LOC_WINDOW);

    codec_pointer_reg #(.DW(DW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ptr_wr),
        .wdata    (host_wdata),
        .init_we  (tst_init_we),
        .init_val (tst_init_val),
        .ptr_q    (ptr_q)
    );

    codec_index_mask #(.EXTENDED(EXTENDED), .IDX_W(IDX_W)) u_mask (
        .ptr_low   (ptr_q[IDX_W-1:0]),
        .wide_mode (wide_mode),
        .eff_idx   (eff_idx)
    );

    codec_reg_bank #(
        .EXTENDED  (EXTENDED),
        .DW        (DW),
        .DEPTH     (DEPTH),
        .ID_SLOT   (ID_SLOT),
        .ID_VALUE  (ID_VALUE),
        .MISC_SLOT (MISC_SLOT),
        .WIDE_BIT  (WIDE_BIT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (win_wr),
        .idx       (eff_idx),
        .wdata     (host_wdata),
        .rdata     (bank_rdata),
        .wide_mode (wide_mode)
    );

    // Status byte: test load only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (tst_status_we) begin
            status_q <= tst_status_val;
        end
    end

    // Direct location read select
    always_comb begin
        unique case (host_sel)
            LOC_POINTER: sel_data = ptr_q;
            LOC_WINDOW:  sel_data = bank_rdata;
            LOC_STATUS:  sel_data = status_q;
            default:     sel_data = '0;
        endcase
    end

    codec_access_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (host_rd),
        .sel       (host_sel),
        .sel_data  (sel_data),
        .rsp_data  (rsp_data),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault)
    );

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tst_status_we) |=> $stable(status_q)); // R8

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (host_sel == LOC_STATUS)) |=> (rsp_data == $past(status_q))); // R8

    generate
        if (EXTENDED) begin : g_ext_chk
            AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
                (host_rd && (host_sel == LOC_WINDOW) && (eff_idx == IDX_W'(ID_SLOT)))
                |=> (rsp_data == DW'(ID_VALUE))); // R5
        end else begin : g_leg_chk
            AST_LEGACY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
                (eff_idx[IDX_W-1] == 1'b0)); // R4
        end
    endgenerate

endmodule

// File: tb/codec_regport_tb.sv
module codec_regport_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic       tst_status_we = 1'b0;
    logic [7:0] tst_status_val = '0;
    logic       tst_init_we = 1'b0;
    logic       tst_init_val = 1'b0;

    logic [7:0] rsp_data_e, rsp_data_l;
    logic       rsp_valid_e, rsp_valid_l, rsp_fault_e, rsp_fault_l;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    codec_regport #(.EXTENDED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .tst_status_we(tst_status_we),
        .tst_status_val(tst_status_val), .tst_init_we(tst_init_we),
        .tst_init_val(tst_init_val), .rsp_data(rsp_data_e),
        .rsp_valid(rsp_valid_e), .rsp_fault(rsp_fault_e)
    );

    codec_regport #(.EXTENDED(1'b0)) u_dut_leg (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .tst_status_we(tst_status_we),
        .tst_status_val(tst_status_val), .tst_init_we(tst_init_we),
        .tst_init_val(tst_init_val), .rsp_data(rsp_data_l),
        .rsp_valid(rsp_valid_l), .rsp_fault(rsp_fault_l)
    );

    // Requirement model
    logic [7:0] ptr_m = '0;
    logic [7:0] st_m  = '0;
    logic [7:0] bank_e [32];
    logic [7:0] bank_l [32];

    typedef struct {
        logic [7:0] de;
        logic [7:0] dl;
        logic       flt;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    function automatic logic [4:0] eff_ext();
        return bank_e[12][6] ? ptr_m[4:0] : {1'b0, ptr_m[3:0]};
    endfunction

    function automatic logic [4:0] eff_leg();
        return {1'b0, ptr_m[3:0]};
    endfunction

    task automatic drive(input logic w, input logic r, input logic [1:0] a,
                         input logic [7:0] d, input logic sw, input logic [7:0] sv,
                         input logic iw, input logic iv, input string tag);
        exp_t e;
        logic [4:0] ie, il;
        @(negedge clk);
        ie = eff_ext();
        il = eff_leg();
        if (r) begin
            e.tag = tag;
            e.flt = 1'b0;
            case (a)
                2'd0: begin e.de = ptr_m; e.dl = ptr_m; end
                2'd1: begin e.de = (ie == 5'd25) ? 8'hA0 : bank_e[ie]; e.dl = bank_l[il]; end
                2'd2: begin e.de = st_m; e.dl = st_m; end
                default: begin e.de = 8'h00; e.dl = 8'h00; e.flt = 1'b1; end
            endcase
            sb_q.push_back(e);
        end
        if (w && a == 2'd0) ptr_m[6:0] = d[6:0];
        if (w && a == 2'd1) begin bank_e[ie] = d; bank_l[il] = d; end
        if (sw) st_m = sv;
        if (iw) ptr_m[7] = iv;
        host_wr = w; host_rd = r; host_sel = a; host_wdata = d;
        tst_status_we = sw; tst_status_val = sv; tst_init_we = iw; tst_init_val = iv;
        @(posedge clk);
        #1;
        host_wr = 1'b0; host_rd = 1'b0; tst_status_we = 1'b0; tst_init_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        drive(1'b1, 1'b0, a, d, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        drive(1'b0, 1'b1, a, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare each response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (rsp_valid_e || rsp_fault_e || rsp_valid_l || rsp_fault_l)) begin
            n_tests++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6: unexpected response ext=%h/%b/%b leg=%h/%b/%b expected none",
                         rsp_data_e, rsp_valid_e, rsp_fault_e, rsp_data_l, rsp_valid_l, rsp_fault_l);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rsp_data_e !== e.de || rsp_valid_e !== !e.flt || rsp_fault_e !== e.flt ||
                    rsp_data_l !== e.dl || rsp_valid_l !== !e.flt || rsp_fault_l !== e.flt) begin
                    n_fail++;
                    $display("FAIL %s: ext=%h v%b f%b leg=%h v%b f%b expected ext=%h leg=%h fault=%b",
                             e.tag, rsp_data_e, rsp_valid_e, rsp_fault_e,
                             rsp_data_l, rsp_valid_l, rsp_fault_l, e.de, e.dl, e.flt);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin bank_e[i] = 8'h00; bank_l[i] = 8'h00; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (rsp_valid_e || rsp_fault_e || rsp_valid_l || rsp_fault_l) begin
            n_fail++;
            $display("FAIL R1: after reset valid/fault ext=%b%b leg=%b%b expected 00",
                     rsp_valid_e, rsp_fault_e, rsp_valid_l, rsp_fault_l);
        end
        // R1: reset contents
        rd(2'd0, "R1");
        rd(2'd2, "R1");
        rd(2'd1, "R1");
        // R10 / R2: pointer write and window round trip
        wr(2'd0, 8'h05, "R2");
        rd(2'd0, "R2");
        wr(2'd1, 8'h3C, "R10");
        rd(2'd1, "R10");
        // R2: init flag from test input, kept across bus writes
        drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, "R2");
        rd(2'd0, "R2");
        wr(2'd0, 8'h7F, "R2");
        rd(2'd0, "R2");
        wr(2'd0, 8'h00, "R2");
        rd(2'd0, "R2");
        wr(2'd0, 8'h7F, "R3");
        wr(2'd1, 8'h11, "R3");
        rd(2'd1, "R3");
        // R3 / R4: set the wide-index mode bit in slot 12
        wr(2'd0, 8'h1C, "R3");
        rd(2'd1, "R3");
        wr(2'd1, 8'h40, "R3");
        rd(2'd1, "R4");
        wr(2'd0, 8'h0C, "R4");
        rd(2'd1, "R4");
        wr(2'd0, 8'h1C, "R4");
        // R5: identification slot
        wr(2'd0, 8'h19, "R5");
        wr(2'd1, 8'h55, "R5");
        rd(2'd1, "R5");
        wr(2'd0, 8'h10, "R4");
        wr(2'd1, 8'h77, "R4");
        rd(2'd1, "R4");
        // R6: back-to-back reads
        rd(2'd1, "R6");
        rd(2'd0, "R6");
        rd(2'd1, "R6");
        // R8: status load and ignored writes
        drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h5A, 1'b0, 1'b0, "R8");
        rd(2'd2, "R8");
        wr(2'd2, 8'hFF, "R8");
        wr(2'd3, 8'hFF, "R8");
        rd(2'd2, "R8");
        rd(2'd0, "R8");
        rd(2'd1, "R8");
        // R7: programmed-I/O read
        rd(2'd3, "R7");
        rd(2'd0, "R7");
        rd(2'd3, "R7");
        // R9: coinciding read and write
        drive(1'b1, 1'b1, 2'd0, 8'h03, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        rd(2'd0, "R9");
        drive(1'b0, 1'b1, 2'd2, 8'h00, 1'b1, 8'hC3, 1'b0, 1'b0, "R9");
        rd(2'd2, "R9");
        drive(1'b1, 1'b1, 2'd1, 8'hE1, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        rd(2'd1, "R9");
        drive(1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R9");
        rd(2'd0, "R9");
        // R10: sweep all pointer values
        for (int i = 0; i < 32; i++) begin
            wr(2'd0, 8'(i), "R10");
            wr(2'd1, 8'(i) ^ 8'h5A, "R10");
        end
        for (int i = 0; i < 32; i++) begin
            wr(2'd0, 8'(i), "R10");
            rd(2'd1, "R10");
        end
        repeat (4) @(negedge clk);
        n_tests++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R6: %0d responses missing, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule